// File: doc/BRIEF.md
# Delta Modulation Output Unit

This block is the playback half of a one-bit delta audio channel. A period timer, whose reload value comes from a 16-entry table selected by a rate index, produces a one-cycle tick. On each tick the unit takes one bit from an 8-bit shift register. A 1 raises a 7-bit output level by 2 and a 0 lowers it by 2. In both directions the level stays inside its range and holds at the edge rather than wrapping.

Every eight ticks the unit reaches a byte boundary. If the external one-byte sample buffer holds data at that point, the byte moves into the shift register. The unit then pulses both a buffer-consumed output and a fetch-request output, so the memory reader can refill the buffer. If the buffer is empty, the unit goes silent for the next eight ticks. While silent, the level holds but the bit counter keeps running. A direct-load strobe writes a new level at once, outside the tick schedule, and it takes priority over a step that lands in the same cycle. A configuration input picks the bit order: least significant bit first, or most significant bit first.

Top module: `dmc_output_unit`

## Requirements
- R1: On a non-silent tick that takes a 1 bit, the level rises by 2 only when it is 125 or less; at 126 or 127 it holds.
- R2: On a non-silent tick that takes a 0 bit, the level falls by 2 only when it is 2 or more; at 0 or 1 it holds.
- R3: With `msb_first` = 0 the shift register gives up bit 0 first and shifts right. With `msb_first` = 1 it gives up bit 7 first and shifts left.
- R4: The bit counter counts down on every tick, silent or not. A byte boundary therefore falls every 8 ticks whether or not a byte was played.
- R5: At a byte boundary with `buf_full` = 1, the unit loads `buf_data` into the shift register and leaves silence. `buf_taken` and `fetch_req` go high together for exactly one cycle, in the cycle right after the boundary tick.
- R6: At a byte boundary with `buf_full` = 0, the unit enters silence and raises no pulse. The level holds through the next 8 ticks.
- R7: When `dload_we` is high at a clock edge, the level after that edge equals `dload_val` AND 0x7F.
- R8: When a direct load and a delta step fall on the same edge, the direct-load value is the level that results.
- R9: The tick period in clock cycles is the table entry for `rate_idx`. The table runs 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54 for indices 0 to 15. The rate index is sampled when the timer reloads.
- R10: Reset leaves the level at 0, both pulses low, the bit counter at 8 and the unit silent. The timer is preloaded to the index-0 period minus 1, so the first tick comes 428 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one timer count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_idx | input | 4 | Index into the period table |
| msb_first | input | 1 | 1 selects most-significant-bit-first playback |
| buf_full | input | 1 | Sample buffer holds a byte |
| buf_data | input | 8 | Byte held in the sample buffer |
| dload_we | input | 1 | Direct level load strobe |
| dload_val | input | 8 | Direct load value; bit 7 is ignored |
| level | output | 7 | Current output level |
| buf_taken | output | 1 | One-cycle pulse: the buffer byte was consumed |
| fetch_req | output | 1 | One-cycle pulse: request the next sample byte |

## Verification
The bench pushes the level at both saturation edges. It starts at 126 with a byte of all ones, and at 3 and 0 with bytes of zeros. A design with an off-by-one bound would step to 127 or 128, or wrap below zero. The bench plays the same byte in both bit orders at a level where the two orders end up in different places, so a swapped or ignored order select shows up as a wrong level. It times every gap between pulses, including a gap that spans a silent byte, a change of rate and the first byte after reset. A counter that stalls during silence, a table entry that is not reduced by one, or a wrong reset preload shows up as a shifted pulse. It also places a direct load on the exact edge of a tick, so a design that lets the step win over the load leaves a level that is off by 2.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   localparam int unsigned RATE_W = 4;
   localparam int unsigned MAX_RATE_CYCLES = 428;
   localparam int unsigned MIN_RATE_CYCLES = 54;

   // Clock cycles between timer ticks for each rate index.
   function automatic int unsigned rate_cycles(input logic [RATE_W-1:0] idx);
      case (idx)
         4'd0:    return 428;
         4'd1:    return 380;
         4'd2:    return 340;
         4'd3:    return 320;
         4'd4:    return 286;
         4'd5:    return 254;
         4'd6:    return 226;
         4'd7:    return 214;
         4'd8:    return 190;
         4'd9:    return 160;
         4'd10:   return 142;
         4'd11:   return 128;
         4'd12:   return 106;
         4'd13:   return 84;
         4'd14:   return 72;
         default: return 54;
      endcase
   endfunction

endpackage

// File: rtl/dmc_rate_timer.sv
module dmc_rate_timer #(
   parameter int TIMER_W = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [dmc_pkg::RATE_W-1:0] rate_idx,
   output logic                       tick
);
   localparam logic [TIMER_W-1:0] PRELOAD =
      TIMER_W'(dmc_pkg::rate_cycles('0) - 1);

   logic [TIMER_W-1:0] count_q;
   logic [TIMER_W-1:0] reload;

   assign reload = TIMER_W'(dmc_pkg::rate_cycles(rate_idx) - 1);
   assign tick   = (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= PRELOAD;
      end else if (tick) begin
         count_q <= reload;
      end else begin
         count_q <= count_q - 1'b1;
      end
   end
endmodule

// File: rtl/dmc_bit_shifter.sv
module dmc_bit_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              msb_first,
   input  logic              buf_full,
   input  logic [BYTE_W-1:0] buf_data,
   output logic              bit_valid,
   output logic              bit_val,
   output logic              consume
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(BYTE_W);

   logic [BYTE_W-1:0] shreg_q;
   logic [CNT_W-1:0]  left_q;
   logic              silent_q;
   logic              consume_q;
   logic [BYTE_W-1:0] shreg_next;

   assign bit_valid = tick && !silent_q;
   assign bit_val   = msb_first ? shreg_q[BYTE_W-1] : shreg_q[0];
   assign consume   = consume_q;

   always_comb begin
      if (msb_first) shreg_next = {shreg_q[BYTE_W-2:0], 1'b0};
      else           shreg_next = {1'b0, shreg_q[BYTE_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q   <= '0;
         left_q    <= FULL_COUNT;
         silent_q  <= 1'b1;
         consume_q <= 1'b0;
      end else begin
         consume_q <= 1'b0;
         if (tick) begin
            if (!silent_q) shreg_q <= shreg_next;
            if (left_q == CNT_W'(1)) begin
               left_q <= FULL_COUNT;
               if (buf_full) begin
                  silent_q  <= 1'b0;
                  shreg_q   <= buf_data;
                  consume_q <= 1'b1;
               end else begin
                  silent_q  <= 1'b1;
               end
            end else begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dmc_level_acc.sv
module dmc_level_acc #(
   parameter int LEVEL_W = 7,
   parameter int BYTE_W  = 8,
   parameter int STEP    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step_en,
   input  logic               step_up,
   input  logic               load_en,
   input  logic [BYTE_W-1:0]  load_val,
   output logic [LEVEL_W-1:0] level
);
   localparam int LVL_MAX = (2 ** LEVEL_W) - 1;
   localparam logic [LEVEL_W-1:0] UP_LIMIT = LEVEL_W'(LVL_MAX - STEP);
   localparam logic [LEVEL_W-1:0] STEP_V   = LEVEL_W'(STEP);
   localparam logic [BYTE_W-1:0]  LOAD_MASK = BYTE_W'(LVL_MAX);

   logic [LEVEL_W-1:0] level_q;

   assign level = level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (load_en) begin
         level_q <= LEVEL_W'(load_val & LOAD_MASK);
      end else if (step_en) begin
         if (step_up) begin
            if (level_q <= UP_LIMIT) level_q <= level_q + STEP_V;
         end else begin
            if (level_q >= STEP_V) level_q <= level_q - STEP_V;
         end
      end
   end
endmodule

// File: rtl/dmc_output_unit.sv
module dmc_output_unit #(
   parameter int LEVEL_W = 7,
   parameter int BYTE_W  = 8,
   parameter int TIMER_W = 9,
   parameter int STEP    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [dmc_pkg::RATE_W-1:0] rate_idx,
   input  logic                       msb_first,
   input  logic                       buf_full,
   input  logic [BYTE_W-1:0]          buf_data,
   input  logic                       dload_we,
   input  logic [BYTE_W-1:0]          dload_val,
   output logic [LEVEL_W-1:0]         level,
   output logic                       buf_taken,
   output logic                       fetch_req
);
   localparam int TIMER_NEED = $clog2(dmc_pkg::MAX_RATE_CYCLES);

   generate
      if (TIMER_W < TIMER_NEED) begin : g_bad_timer_w
         $error("TIMER_W too narrow for the longest period");
      end
      if (LEVEL_W > BYTE_W) begin : g_bad_level_w
         $error("LEVEL_W must not exceed BYTE_W");
      end
      if (STEP < 1 || STEP >= (2 ** LEVEL_W)) begin : g_bad_step
         $error("STEP out of range for LEVEL_W");
      end
   endgenerate

   logic tick;
   logic bit_valid;
   logic bit_val;
   logic consume;

   dmc_rate_timer #(.TIMER_W(TIMER_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_idx (rate_idx),
      .tick     (tick)
   );

   dmc_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .msb_first (msb_first),
      .buf_full  (buf_full),
      .buf_data  (buf_data),
      .bit_valid (bit_valid),
      .bit_val   (bit_val),
      .consume   (consume)
   );

   dmc_level_acc #(.LEVEL_W(LEVEL_W), .BYTE_W(BYTE_W), .STEP(STEP)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (bit_valid),
      .step_up  (bit_val),
      .load_en  (dload_we),
      .load_val (dload_val),
      .level    (level)
   );

   assign buf_taken = consume;
   assign fetch_req = consume;
endmodule

// File: rtl/dmc_output_unit_chk.sv
module dmc_output_unit_chk #(
   parameter int LEVEL_W = 7,
   parameter int BYTE_W  = 8,
   parameter int STEP    = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dload_we,
   input logic [BYTE_W-1:0]  dload_val,
   input logic [LEVEL_W-1:0] level,
   input logic               buf_taken,
   input logic               fetch_req
);
   localparam int LVL_MAX = (2 ** LEVEL_W) - 1;
   localparam int MIN_GAP = BYTE_W * dmc_pkg::MIN_RATE_CYCLES;

   logic        pv_q;
   logic [15:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv_q  <= 1'b0;
         gap_q <= '0;
      end else begin
         pv_q <= 1'b1;
         if (fetch_req)          gap_q <= 16'd1;
         else if (gap_q != '1)   gap_q <= gap_q + 16'd1;
      end
   end

   // R7: direct load lands on the next edge, bit 7 dropped
   a_r7_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
      dload_we |=> (int'(level) == (int'($past(dload_val)) & LVL_MAX)));

   // R1: no rise from the top band
   a_r1_top_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pv_q && !$past(dload_we) && int'($past(level)) > LVL_MAX - STEP)
      |-> level <= $past(level));

   // R2: no fall from the bottom band
   a_r2_bottom_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pv_q && !$past(dload_we) && int'($past(level)) < STEP)
      |-> level >= $past(level));

   // R1, R2: a step moves by exactly STEP
   a_r1_step_size: assert property (@(posedge clk) disable iff (!rst_n)
      (pv_q && !$past(dload_we) && level != $past(level))
      |-> (int'(level) == int'($past(level)) + STEP ||
           int'(level) + STEP == int'($past(level))));

   // R5: both pulses together
   a_r5_pulse_pair: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req == buf_taken);

   // R5: pulse lasts one cycle
   a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |=> !fetch_req);

   // R4, R10: byte boundaries are at least eight shortest periods apart
   a_r4_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> int'(gap_q) >= MIN_GAP);
endmodule

bind dmc_output_unit dmc_output_unit_chk #(
   .LEVEL_W (LEVEL_W),
   .BYTE_W  (BYTE_W),
   .STEP    (STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dload_we  (dload_we),
   .dload_val (dload_val),
   .level     (level),
   .buf_taken (buf_taken),
   .fetch_req (fetch_req)
);

// File: tb/test_dmc_output_unit.sv
`timescale 1ns/1ps
module test_dmc_output_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] rate_idx = 4'd15;
   logic       msb_first = 1'b0;
   logic       buf_full = 1'b1;
   logic [7:0] buf_data = 8'h00;
   logic       dload_we = 1'b0;
   logic [7:0] dload_val = 8'h00;
   logic [6:0] level;
   logic       buf_taken;
   logic       fetch_req;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int last_pulse = 0;
   int cur = 0;
   int exp_q[$];
   bit done = 0;

   always #2.5 clk = ~clk;

   dmc_output_unit i_dmc_output_unit (
      .clk (clk), .rst_n (rst_n), .rate_idx (rate_idx), .msb_first (msb_first),
      .buf_full (buf_full), .buf_data (buf_data), .dload_we (dload_we),
      .dload_val (dload_val), .level (level), .buf_taken (buf_taken),
      .fetch_req (fetch_req)
   );

   always @(posedge clk) if (rst_n) cyc = cyc + 1;

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Reference stepping from the requirements (R1, R2, R3)
   function automatic int play(input int lvl, input int d, input bit msb, input int first);
      for (int i = first; i < 8; i++) begin
         int b;
         b = msb ? (d >> (7 - i)) & 1 : (d >> i) & 1;
         if (b == 1) begin
            if (lvl <= 125) lvl += 2;
         end else if (lvl >= 2) begin
            lvl -= 2;
         end
      end
      return lvl;
   endfunction

   // Monitor: pops the expected level at each boundary pulse (R5)
   always @(negedge clk) begin
      if (rst_n && fetch_req) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5 actual=unexpected pulse expected=none (cycle %0d)", cyc);
         end else begin
            check("R1/R2/R3 level at boundary", int'(level), exp_q.pop_front());
         end
         check("R5 buf_taken with fetch_req", int'(buf_taken), 1);
      end
   end

   task automatic wait_pulse(input int gap);
      do @(negedge clk); while (!fetch_req);
      check("R9/R4/R10 cycles between boundaries", cyc - last_pulse, gap);
      last_pulse = cyc;
      #1;
   endtask

   task automatic feed(input int d, input bit msb, input int rate, input int gap);
      buf_data = 8'(d);
      buf_full = 1'b1;
      wait_pulse(gap);
      msb_first = msb;
      rate_idx  = 4'(rate);
      cur = play(cur, d, msb, 0);
      exp_q.push_back(cur);
   endtask

   // Silent byte with a direct load inside it (R6, R7)
   task automatic gap_load(input int val);
      int held;
      buf_full = 1'b0;
      repeat (432) @(negedge clk);
      check("R6 no pulse on empty boundary", int'(fetch_req), 0);
      check("R6 level at empty boundary", int'(level), exp_q.pop_front());
      held = int'(level);
      repeat (200) @(negedge clk);
      check("R6 level holds while silent", int'(level), held);
      dload_val = 8'(val);
      dload_we  = 1'b1;
      @(negedge clk);
      dload_we  = 1'b0;
      check("R7 direct load masked", int'(level), val & 8'h7F);
      cur = val & 8'h7F;
      exp_q.push_back(cur);
   endtask

   // Direct load on the same edge as a tick (R8)
   task automatic feed_collide(input int d, input int val, input int gap);
      buf_data = 8'(d);
      buf_full = 1'b1;
      wait_pulse(gap);
      msb_first = 1'b0;
      repeat (53) @(negedge clk);
      dload_val = 8'(val);
      dload_we  = 1'b1;
      @(negedge clk);
      dload_we  = 1'b0;
      check("R8 direct load wins over step", int'(level), val & 8'h7F);
      cur = play(val & 8'h7F, d, 1'b0, 1);
      exp_q.push_back(cur);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset level", int'(level), 0);
      check("R10 reset fetch_req", int'(fetch_req), 0);
      check("R10 reset buf_taken", int'(buf_taken), 0);
      rst_n = 1'b1;
      exp_q.push_back(0);                 // R10: silent until the first byte
      feed(8'hFF, 1'b0, 15, 806);         // R10 preload, R1 rise
      feed(8'h00, 1'b0, 15, 432);         // R2 fall
      feed(8'hF0, 1'b1, 15, 432);         // R3 MSB first from 0
      feed(8'hF0, 1'b0, 14, 432);         // R3 LSB first, rate change queued
      feed(8'hFF, 1'b0, 14, 558);         // R9 old reload then new
      feed(8'h0F, 1'b1, 15, 576);         // R9 index 14 is 72 cycles
      feed(8'hAA, 1'b0, 15, 450);
      gap_load(8'hFE);                    // R7 mask to 126
      feed(8'hFF, 1'b0, 15, 864);         // R4 counter ran while silent; R1 top hold
      gap_load(8'h83);                    // level 3
      feed(8'h00, 1'b0, 15, 864);         // R2 bottom hold
      feed_collide(8'hFF, 8'h40, 432);    // R8
      feed(8'h00, 1'b0, 15, 432);
      wait_pulse(432);
      #1;
      check("R5 scoreboard drained", exp_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule